// File: doc/BRIEF.md
# Flash Program and Erase Timing Sequencer

This block sequences the four flash array operations: single word programming, burst (block) programming, erase of one segment and mass erase of main memory. Each phase lasts a fixed number of cycles of the slow flash timing clock, on which the whole block runs. Software first writes a keyed control word that selects the operation. A write on the flash data port then starts the operation. The block holds `busy` high for the whole phase. In the last busy cycle it fires a one-cycle strobe toward the array, carrying the latched address, data or segment base.

Block programming keeps `busy` high from the first word until the burst is closed. The first word takes longer than each following word. Between words the block raises `needData`. The burst is closed by switching the mode away from block, which runs a short closing phase.

The topmost information segment is locked after reset. Any program or erase that would touch it is dropped and raises an access-violation flag, until software clears the lock bit. Every control write must carry a key byte. A wrong key raises a sticky key-violation output that asks the system for a reset.

Top module: `fprog_seq`

## Requirements
- R1: After reset, busy, needData, all strobes, accViol and keyViol are low and lockA is high.
- R2: In word mode (control bits [2:0]=1), a flash write holds busy high for exactly 30 cycles, beginning the cycle after the write is captured. progStb pulses once, in the last busy cycle, with arrAddr/arrData equal to the written address and data.
- R3: In block mode (bits [2:0]=2), the first word takes 25 busy cycles and each further word takes 18. progStb fires in the last cycle of each word. needData is high, together with busy, while the next word is awaited.
- R4: While a burst waits for data, writing a mode other than block drops needData one cycle later. busy then stays high for exactly 6 more cycles, with no strobe.
- R5: Segment erase (bits [2:0]=3) takes 4819 busy cycles and ends with one eraseStb. arrAddr is the address rounded down to 512 bytes in main memory, or to 64 bytes in information memory (0x1000 to 0x10FF).
- R6: Mass erase (bits [2:0]=4) takes 10593 busy cycles and ends with one massStb. massInfo repeats control bit 3, which asks for information memory to be erased as well.
- R7: While lockA is high, a word or block write or a segment erase addressed to 0x10C0 to 0x10FF is dropped, with no busy and no strobe, and accViol is set. A mass erase with bit 3 set is dropped in the same way.
- R8: A keyed write to the lock register (regSel=1), with bit 0 cleared, drops lockA and allows operations on the locked segment.
- R9: A flash write while busy (except while needData is high) or in off mode (bits [2:0]=0) is dropped and sets accViol. The running operation keeps its timing, address and data.
- R10: Every register write must carry 0xC3 in regData[15:8]. A write with any other upper byte changes no register and sets keyViol, which stays high until reset.
- R11: A keyed control write with bit 7 set clears accViol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Flash timing clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWr | input | 1 | Register write strobe |
| regSel | input | 1 | 0 selects the control register, 1 selects the lock register |
| regData | input | 16 | Key byte in [15:8], register value in [7:0] |
| memWr | input | 1 | Flash write strobe that starts or feeds an operation |
| memAddr | input | 16 | Flash byte address |
| memData | input | 16 | Data word to program |
| busy | output | 1 | An operation is in progress |
| needData | output | 1 | A burst is waiting for its next word |
| progStb | output | 1 | One-cycle program strobe to the array |
| eraseStb | output | 1 | One-cycle segment erase strobe |
| massStb | output | 1 | One-cycle mass erase strobe |
| massInfo | output | 1 | Mass erase also covers information memory |
| arrAddr | output | 16 | Address or segment base that goes with a strobe |
| arrData | output | 16 | Data that goes with progStb |
| accViol | output | 1 | Sticky flag for a dropped access |
| keyViol | output | 1 | Sticky wrong-key flag; requests a reset |
| lockA | output | 1 | Lock state of the top information segment |

## Verification
On every cycle the assertions check these relations. busy rises only after a captured flash write. needData and every strobe occur only inside busy, and at most one strobe fires at a time. The phase counter never exceeds the longest phase. keyViol never falls, and a bad-key write leaves the lock unchanged. A write to the locked segment never starts an operation. The exact phase lengths, the placement of each strobe in the last busy cycle, and the rounding of segment bases can only be shown by the bench scenarios. So can the burst close sequence and the survival of an operation that receives a stray write.

// File: rtl/fprog_pkg.sv
package fprog_pkg;
  typedef enum logic [2:0] {
    MODE_OFF   = 3'd0,
    MODE_WORD  = 3'd1,
    MODE_BLOCK = 3'd2,
    MODE_SEG   = 3'd3,
    MODE_MASS  = 3'd4
  } mode_e;

  typedef enum logic [2:0] {
    PH_WORD, PH_BFIRST, PH_BNEXT, PH_BEND, PH_SEG, PH_MASS
  } phase_e;

  typedef struct packed {
    logic   load;
    phase_e phase;
    logic   incl;
  } dpCmd_t;
endpackage

// File: rtl/fprog_dp.sv
module fprog_dp
  import fprog_pkg::*;
#(
  parameter int ADDR_W         = 16,
  parameter int DATA_W         = 16,
  parameter int T_WORD         = 30,
  parameter int T_BFIRST       = 25,
  parameter int T_BNEXT        = 18,
  parameter int T_BEND         = 6,
  parameter int T_SEG          = 4819,
  parameter int T_MASS         = 10593,
  parameter int INFO_BASE      = 'h1000,
  parameter int INFO_SEGS      = 4,
  parameter int INFO_SEG_BYTES = 64,
  parameter int MAIN_SEG_BYTES = 512
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memData,
  output logic              done,
  output logic              hitLocked,
  output logic              progStb,
  output logic              eraseStb,
  output logic              massStb,
  output logic              massInfo,
  output logic [ADDR_W-1:0] arrAddr,
  output logic [DATA_W-1:0] arrData
);
  localparam int CNT_W     = $clog2(T_MASS + 1);
  localparam int INFO_END  = INFO_BASE + INFO_SEGS * INFO_SEG_BYTES;
  localparam int LOCK_BASE = INFO_BASE + (INFO_SEGS - 1) * INFO_SEG_BYTES;
  localparam logic [ADDR_W-1:0] INFO_MASK = ~ADDR_W'(INFO_SEG_BYTES - 1);
  localparam logic [ADDR_W-1:0] MAIN_MASK = ~ADDR_W'(MAIN_SEG_BYTES - 1);

  logic [CNT_W-1:0]  cnt;
  phase_e            phaseQ;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic              inclQ;
  logic              inInfo;
  logic [ADDR_W-1:0] segBase;

  function automatic logic [CNT_W-1:0] periodOf(phase_e p);
    case (p)
      PH_WORD:   return CNT_W'(T_WORD);
      PH_BFIRST: return CNT_W'(T_BFIRST);
      PH_BNEXT:  return CNT_W'(T_BNEXT);
      PH_BEND:   return CNT_W'(T_BEND);
      PH_SEG:    return CNT_W'(T_SEG);
      default:   return CNT_W'(T_MASS);
    endcase
  endfunction

  always_comb begin
    inInfo    = (int'(memAddr) >= INFO_BASE) && (int'(memAddr) < INFO_END);
    segBase   = inInfo ? (memAddr & INFO_MASK) : (memAddr & MAIN_MASK);
    hitLocked = (int'(memAddr) >= LOCK_BASE) && (int'(memAddr) < INFO_END);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      phaseQ <= PH_WORD;
      addrQ  <= '0;
      dataQ  <= '0;
      inclQ  <= 1'b0;
    end else if (cmd.load) begin
      cnt    <= periodOf(cmd.phase);
      phaseQ <= cmd.phase;
      inclQ  <= cmd.incl;
      if (cmd.phase == PH_SEG)       addrQ <= segBase;
      else if (cmd.phase == PH_MASS) addrQ <= '0;
      else if (cmd.phase != PH_BEND) addrQ <= memAddr;
      if (cmd.phase != PH_BEND)      dataQ <= memData;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign done     = (cnt == CNT_W'(1));
  assign progStb  = done && (phaseQ inside {PH_WORD, PH_BFIRST, PH_BNEXT});
  assign eraseStb = done && (phaseQ == PH_SEG);
  assign massStb  = done && (phaseQ == PH_MASS);
  assign massInfo = inclQ;
  assign arrAddr  = addrQ;
  assign arrData  = dataQ;

  // R6
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(cnt) <= T_MASS);
  // R5
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({progStb, eraseStb, massStb}));
endmodule

// File: rtl/fprog_ctrl.sv
module fprog_ctrl
  import fprog_pkg::*;
#(
  parameter logic [7:0] KEY = 8'hC3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWr,
  input  logic        regSel,
  input  logic [15:0] regData,
  input  logic        memWr,
  input  logic        hitLocked,
  input  logic        done,
  output dpCmd_t      cmd,
  output logic        busy,
  output logic        needData,
  output logic        accViol,
  output logic        keyViol,
  output logic        lockA
);
  typedef enum logic [2:0] {S_IDLE, S_RUN, S_BPROG, S_BWAIT, S_BEND} state_e;

  state_e state, stateNxt;
  mode_e  modeQ;
  logic   inclQ;
  logic   violSet;
  logic   keyOk;

  assign keyOk = (regData[15:8] == KEY);

  always_comb begin
    stateNxt  = state;
    cmd.load  = 1'b0;
    cmd.phase = PH_WORD;
    cmd.incl  = inclQ;
    violSet   = 1'b0;
    case (state)
      S_IDLE: if (memWr) begin
        case (modeQ)
          MODE_WORD: if (hitLocked && lockA) violSet = 1'b1;
                     else begin cmd.load = 1'b1; cmd.phase = PH_WORD; stateNxt = S_RUN; end
          MODE_BLOCK: if (hitLocked && lockA) violSet = 1'b1;
                     else begin cmd.load = 1'b1; cmd.phase = PH_BFIRST; stateNxt = S_BPROG; end
          MODE_SEG:  if (hitLocked && lockA) violSet = 1'b1;
                     else begin cmd.load = 1'b1; cmd.phase = PH_SEG; stateNxt = S_RUN; end
          MODE_MASS: if (inclQ && lockA) violSet = 1'b1;
                     else begin cmd.load = 1'b1; cmd.phase = PH_MASS; stateNxt = S_RUN; end
          default:   violSet = 1'b1;
        endcase
      end
      S_RUN, S_BEND: begin
        violSet = memWr;
        if (done) stateNxt = S_IDLE;
      end
      S_BPROG: begin
        violSet = memWr;
        if (done) stateNxt = S_BWAIT;
      end
      S_BWAIT: begin
        if (modeQ != MODE_BLOCK) begin
          violSet   = memWr;
          cmd.load  = 1'b1;
          cmd.phase = PH_BEND;
          stateNxt  = S_BEND;
        end else if (memWr) begin
          if (hitLocked && lockA) violSet = 1'b1;
          else begin cmd.load = 1'b1; cmd.phase = PH_BNEXT; stateNxt = S_BPROG; end
        end
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      modeQ   <= MODE_OFF;
      inclQ   <= 1'b0;
      lockA   <= 1'b1;
      accViol <= 1'b0;
      keyViol <= 1'b0;
    end else begin
      state <= stateNxt;
      if (violSet) accViol <= 1'b1;
      else if (regWr && keyOk && !regSel && regData[7]) accViol <= 1'b0;
      if (regWr) begin
        if (!keyOk) keyViol <= 1'b1;
        else if (!regSel) begin
          modeQ <= mode_e'(regData[2:0]);
          inclQ <= regData[3];
        end else begin
          lockA <= regData[0];
        end
      end
    end
  end

  assign busy     = (state != S_IDLE);
  assign needData = (state == S_BWAIT);

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(memWr));
  // R3
  need_in_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    needData |-> busy);
  // R10
  key_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    keyViol |=> keyViol);
  // R10
  bad_key_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && !keyOk) |=> $stable(lockA));
  // R7
  locked_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && memWr && hitLocked && lockA &&
     (modeQ inside {MODE_WORD, MODE_BLOCK, MODE_SEG})) |=> (!busy && accViol));
endmodule

// File: rtl/fprog_seq.sv
module fprog_seq
  import fprog_pkg::*;
#(
  parameter logic [7:0] KEY = 8'hC3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWr,
  input  logic        regSel,
  input  logic [15:0] regData,
  input  logic        memWr,
  input  logic [15:0] memAddr,
  input  logic [15:0] memData,
  output logic        busy,
  output logic        needData,
  output logic        progStb,
  output logic        eraseStb,
  output logic        massStb,
  output logic        massInfo,
  output logic [15:0] arrAddr,
  output logic [15:0] arrData,
  output logic        accViol,
  output logic        keyViol,
  output logic        lockA
);
  dpCmd_t cmd;
  logic   done;
  logic   hitLocked;

  fprog_ctrl #(.KEY(KEY)) uCtrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regSel(regSel), .regData(regData),
    .memWr(memWr), .hitLocked(hitLocked), .done(done), .cmd(cmd),
    .busy(busy), .needData(needData), .accViol(accViol), .keyViol(keyViol),
    .lockA(lockA)
  );

  fprog_dp #(.ADDR_W(16), .DATA_W(16)) uDp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .memAddr(memAddr), .memData(memData),
    .done(done), .hitLocked(hitLocked), .progStb(progStb), .eraseStb(eraseStb),
    .massStb(massStb), .massInfo(massInfo), .arrAddr(arrAddr), .arrData(arrData)
  );

  // R2
  strobe_in_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (progStb || eraseStb || massStb) |-> busy);
endmodule

// File: tb/tb_fprog_seq.sv
module tb_fprog_seq;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] KEY = 8'hC3;

  typedef struct packed {
    logic [2:0]  mode;
    logic        incl;
    logic [15:0] addr;
    logic [15:0] data;
    logic [15:0] cycles;
    logic [1:0]  kind;   // 0 none, 1 program, 2 segment erase, 3 mass erase
    logic [15:0] expAddr;
    logic        viol;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{3'd1, 1'b0, 16'hF802, 16'h1234, 16'd30,    2'd1, 16'hF802, 1'b0},
    '{3'd1, 1'b0, 16'h1040, 16'hBEEF, 16'd30,    2'd1, 16'h1040, 1'b0},
    '{3'd1, 1'b0, 16'h10C4, 16'h5555, 16'd0,     2'd0, 16'h0000, 1'b1},
    '{3'd3, 1'b0, 16'hF9A6, 16'h0000, 16'd4819,  2'd2, 16'hF800, 1'b0},
    '{3'd3, 1'b0, 16'h1093, 16'h0000, 16'd4819,  2'd2, 16'h1080, 1'b0},
    '{3'd3, 1'b0, 16'h10FF, 16'h0000, 16'd0,     2'd0, 16'h0000, 1'b1},
    '{3'd4, 1'b0, 16'hFC00, 16'h0000, 16'd10593, 2'd3, 16'h0000, 1'b0},
    '{3'd4, 1'b1, 16'hFC00, 16'h0000, 16'd0,     2'd0, 16'h0000, 1'b1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWr = 1'b0, regSel = 1'b0, memWr = 1'b0;
  logic [15:0] regData = '0, memAddr = '0, memData = '0;
  logic busy, needData, progStb, eraseStb, massStb, massInfo;
  logic [15:0] arrAddr, arrData;
  logic accViol, keyViol, lockA;

  int total = 0;
  int bad = 0;

  int cyc, stbCnt, stbAt, stbKind;
  logic [15:0] sAddr, sData;
  logic sInfo;

  always #(CLK_PERIOD/2) clk = ~clk;

  fprog_seq #(.KEY(KEY)) dut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regSel(regSel), .regData(regData),
    .memWr(memWr), .memAddr(memAddr), .memData(memData), .busy(busy),
    .needData(needData), .progStb(progStb), .eraseStb(eraseStb),
    .massStb(massStb), .massInfo(massInfo), .arrAddr(arrAddr), .arrData(arrData),
    .accViol(accViol), .keyViol(keyViol), .lockA(lockA)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic sel, input logic [15:0] d);
    @(negedge clk);
    regWr = 1'b1; regSel = sel; regData = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic setCtrl(input logic [2:0] mode, input logic incl, input logic clr);
    regWrite(1'b0, {KEY, clr, 3'b000, incl, mode});
  endtask

  task automatic memWrite(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    memWr = 1'b1; memAddr = a; memData = d;
    @(negedge clk);
    memWr = 1'b0;
  endtask

  // Counts busy cycles until busy falls or needData rises; optionally injects a stray write.
  task automatic runOp(input int injectAt, input logic [15:0] injAddr);
    cyc = 0; stbCnt = 0; stbAt = 0; stbKind = 0;
    while (busy && !needData && cyc < 20000) begin
      cyc++;
      if (progStb || eraseStb || massStb) begin
        stbCnt++; stbAt = cyc; sAddr = arrAddr; sData = arrData; sInfo = massInfo;
        stbKind = progStb ? 1 : (eraseStb ? 2 : 3);
      end
      if (cyc == injectAt) begin
        memWr = 1'b1; memAddr = injAddr; memData = 16'hDEAD;
      end else memWr = 1'b0;
      @(negedge clk);
    end
    memWr = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!busy && !needData && !progStb && !eraseStb && !massStb, "R1 idle", busy, 0);
    check(lockA == 1'b1, "R1 lock", lockA, 1);
    check(!accViol && !keyViol, "R1 flags", {accViol, keyViol}, 0);

    // Vector table
    for (int i = 0; i < 8; i++) begin
      string tag;
      vec_t v;
      v = VECS[i];
      tag = v.viol ? "R7" : (v.kind == 2'd1 ? "R2" : (v.kind == 2'd2 ? "R5" : "R6"));
      setCtrl(v.mode, v.incl, 1'b1);
      memWrite(v.addr, v.data);
      runOp(0, 16'h0);
      check(cyc == int'(v.cycles), tag, cyc, v.cycles);
      check(stbCnt == (v.kind != 0 ? 1 : 0) && stbKind == int'(v.kind), tag, stbKind, v.kind);
      if (v.kind != 0) begin
        check(stbAt == int'(v.cycles), tag, stbAt, v.cycles);
        check(sAddr == v.expAddr, tag, sAddr, v.expAddr);
      end
      if (v.kind == 2'd1) check(sData == v.data, tag, sData, v.data);
      if (v.kind == 2'd3) check(sInfo == v.incl, tag, sInfo, v.incl);
      check(accViol == v.viol, tag, accViol, v.viol);
    end

    // R11 clear
    setCtrl(3'd1, 1'b0, 1'b1);
    check(accViol == 1'b0, "R11 clear", accViol, 0);

    // R9 stray write during a word program
    memWrite(16'hF810, 16'hA1A1);
    runOp(5, 16'hF820);
    check(cyc == 30, "R9 timing kept", cyc, 30);
    check(sAddr == 16'hF810 && sData == 16'hA1A1, "R9 addr kept", sAddr, 16'hF810);
    check(accViol == 1'b1, "R9 flag", accViol, 1);

    // R9 off mode
    setCtrl(3'd0, 1'b0, 1'b1);
    memWrite(16'hF830, 16'h0001);
    check(!busy && accViol, "R9 off mode", {busy, accViol}, 1);

    // R8 unlock and write the locked segment
    setCtrl(3'd1, 1'b0, 1'b1);
    regWrite(1'b1, {KEY, 8'h00});
    check(lockA == 1'b0, "R8 unlock", lockA, 0);
    memWrite(16'h10C4, 16'h7777);
    runOp(0, 16'h0);
    check(cyc == 30 && sAddr == 16'h10C4, "R8 write", cyc, 30);
    check(accViol == 1'b0, "R8 no viol", accViol, 0);
    regWrite(1'b1, {KEY, 8'h01});

    // R3/R4 block program
    setCtrl(3'd2, 1'b0, 1'b1);
    memWrite(16'hF900, 16'h0101);
    runOp(0, 16'h0);
    check(cyc == 25 && stbAt == 25, "R3 first", cyc, 25);
    check(needData && busy, "R3 needData", needData, 1);
    memWrite(16'hF902, 16'h0202);
    runOp(0, 16'h0);
    check(cyc == 18 && stbAt == 18 && sAddr == 16'hF902, "R3 next", cyc, 18);
    memWrite(16'h10C2, 16'h0303);
    check(needData && accViol, "R7 block locked", {needData, accViol}, 3);
    memWrite(16'hF904, 16'h0404);
    runOp(0, 16'h0);
    check(cyc == 18 && sData == 16'h0404, "R3 third", cyc, 18);
    setCtrl(3'd0, 1'b0, 1'b0);
    cyc = 0;
    while (needData && cyc < 10) begin cyc++; @(negedge clk); end
    check(cyc == 1, "R4 needData drop", cyc, 1);
    runOp(0, 16'h0);
    check(cyc == 6 && stbCnt == 0, "R4 end seq", cyc, 6);

    // R10 wrong key
    regWrite(1'b1, 16'h0000);
    check(keyViol == 1'b1, "R10 keyViol", keyViol, 1);
    check(lockA == 1'b1, "R10 unchanged", lockA, 1);
    repeat (3) @(negedge clk);
    check(keyViol == 1'b1, "R10 sticky", keyViol, 1);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(keyViol == 1'b0 && lockA == 1'b1, "R1 R10 after reset", keyViol, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule